// File: doc/BRIEF.md
# Multi-Cycle Instruction Cycle Controller

This block is a small processor control unit that runs one instruction at a time over a sequence of subcycles. It owns a program counter, a memory address holding register, a memory data buffer, an instruction holding register, an accumulator and a stack pointer. Every memory transfer uses the address holding register for its address and the data buffer for its data. The only data path to the outside world is one synchronous memory port. An access starts with a read or write strobe, and the memory ends it by raising a ready pulse after any number of wait cycles.

Each instruction goes through the same steps. First comes fetch. If the instruction word requests it, an indirect operand-address read follows. Then comes execute. At the end of execute, the block checks whether an interrupt should be taken. When one is taken, the block pushes the program counter to the stack location and moves the stack pointer down by one. It then clears its interrupt enable flag and continues fetching at a fixed vector. The flag is set by reset only, so interrupts do not nest.

Instruction word: bits [15:12] select the operation, bit 11 selects indirect addressing, and bits [10:0] hold the operand address.

Top module: `icc_core`

## Requirements
- R1: While reset is low, neither mem_rd nor mem_wr is asserted and irq_en reads 1. The first access after reset is a read at address RESET_PC (0).
- R2: Each instruction is fetched by a read at the program counter. Unless a jump or an interrupt intervenes, the next fetch is at that address plus one.
- R3: Opcode 1 (load) copies the word at the effective address into the accumulator. Opcode 3 (add) adds that word to the accumulator modulo 2^16. With bit 11 clear, the effective address is bits [10:0].
- R4: With bit 11 set, exactly one extra read is made at bits [10:0] before execute. The low 11 bits of the returned word become the effective address.
- R5: Opcode 2 (store) writes the accumulator to the effective address.
- R6: Opcode 4 (jump) makes the next fetch come from the effective address. Jump, opcode 0 and every unassigned opcode (5 to 15) make no data access.
- R7: A read or write strobe, together with its address and write data, stays unchanged until mem_ready is seen. mem_rd and mem_wr are never high together.
- R8: When irq and irq_en are both high at the end of execute, the next access writes the program counter to SP_INIT (0x7FF). The fetch after that is at IRQ_VEC (0x100), and irq_en drops to 0.
- R9: While irq_en is 0, irq has no effect and fetching goes on in program order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mem_addr | output | 11 | Memory address, taken from the address holding register |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 16 | Write data, taken from the data buffer |
| mem_rdata | input | 16 | Read data, valid while mem_ready is high |
| mem_ready | input | 1 | Access complete |
| irq | input | 1 | Interrupt request, level sensitive |
| irq_en | output | 1 | Interrupt enable flag |

## Verification
One program exercises direct and indirect load, add with a carry out of bit 15, direct and indirect store, a no-op, an unassigned opcode, and direct and indirect jumps. It runs once with zero-wait memory and once with three wait cycles per access. The zero-wait run shows that no access is skipped or repeated. The wait-state run shows that every access holds until ready. The indirect pointer carries set upper bits, which shows that only its low 11 bits form the address. The interrupt request rises during a jump-to-self loop, which pins the pushed value to the jump target and not to the fetch address plus one. The request is then held high through a second loop, which shows it is ignored once the enable flag has cleared.

// File: rtl/icc_pkg.sv
// Shared definitions for the instruction cycle controller.
// Assumes a 16-bit instruction word with a 4-bit opcode at the top.
package icc_pkg;

    localparam logic [3:0] OP_NOP   = 4'd0;
    localparam logic [3:0] OP_LOAD  = 4'd1;
    localparam logic [3:0] OP_STORE = 4'd2;
    localparam logic [3:0] OP_ADD   = 4'd3;
    localparam logic [3:0] OP_JUMP  = 4'd4;

    typedef enum logic [3:0] {
        S_FETCH_A,   // program counter -> address register
        S_FETCH_M,   // instruction read in flight
        S_LOAD_IR,   // data buffer -> instruction register
        S_IND_A,     // operand pointer -> address register
        S_IND_M,     // pointer read in flight
        S_EXEC_A,    // effective address -> address register
        S_EXEC_RD,   // operand read in flight
        S_EXEC_OP,   // accumulator update
        S_EXEC_WR,   // store write in flight
        S_CHECK,     // end of execute, interrupt sample point
        S_INT_A,     // program counter -> data buffer, stack pointer -> address
        S_INT_WR     // push write in flight
    } state_e;

endpackage

// File: rtl/icc_fsm.sv
// Subcycle sequencer. Walks fetch, optional indirect, execute and
// interrupt subcycles. Assumes the memory raises ready for one cycle
// per access, and that opcodes outside the assigned set act as no-ops.
module icc_fsm
    import icc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mem_ready,
    input  logic       irq,
    input  logic       irq_en,
    input  logic       mbr_ind,
    input  logic [3:0] ir_op,
    output state_e     st
);

    state_e st_nxt;

    // Next-state selection for every subcycle.
    always_comb begin
        st_nxt = st;
        unique case (st)
            S_FETCH_A: st_nxt = S_FETCH_M;
            S_FETCH_M: if (mem_ready) st_nxt = S_LOAD_IR;
            S_LOAD_IR: st_nxt = mbr_ind ? S_IND_A : S_EXEC_A;
            S_IND_A:   st_nxt = S_IND_M;
            S_IND_M:   if (mem_ready) st_nxt = S_EXEC_A;
            S_EXEC_A: begin
                if (ir_op == OP_LOAD || ir_op == OP_ADD) st_nxt = S_EXEC_RD;
                else if (ir_op == OP_STORE)              st_nxt = S_EXEC_WR;
                else                                     st_nxt = S_CHECK;
            end
            S_EXEC_RD: if (mem_ready) st_nxt = S_EXEC_OP;
            S_EXEC_OP: st_nxt = S_CHECK;
            S_EXEC_WR: if (mem_ready) st_nxt = S_CHECK;
            S_CHECK:   st_nxt = (irq && irq_en) ? S_INT_A : S_FETCH_A;
            S_INT_A:   st_nxt = S_INT_WR;
            S_INT_WR:  if (mem_ready) st_nxt = S_FETCH_A;
            default:   st_nxt = S_FETCH_A;
        endcase
    end

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) st <= S_FETCH_A;
        else        st <= st_nxt;
    end

endmodule

// File: rtl/icc_regs.sv
// Data path registers: program counter, address register, data buffer,
// instruction register, accumulator, stack pointer and interrupt enable.
// Assumes AW <= DW-5 so the address field fits below the indirect bit.
module icc_regs
    import icc_pkg::*;
#(
    parameter int          DW       = 16,
    parameter int          AW       = 11,
    parameter logic [AW-1:0] RESET_PC = '0,
    parameter logic [AW-1:0] SP_INIT  = '1,
    parameter logic [AW-1:0] IRQ_VEC  = AW'(256)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  state_e        st,
    input  logic          mem_ready,
    input  logic [DW-1:0] mem_rdata,
    output logic [AW-1:0] mar,
    output logic [DW-1:0] mbr,
    output logic [DW-1:0] ir,
    output logic          irq_en
);

    localparam int OP_LO   = DW - 4;
    localparam int IND_BIT = DW - 5;

    logic [AW-1:0] pc;
    logic [AW-1:0] sp;
    logic [DW-1:0] acc;
    logic [3:0]    op;
    logic [AW-1:0] ea;

    // Operand address: pointer word for indirect mode, field otherwise.
    always_comb begin
        op = ir[DW-1:OP_LO];
        ea = ir[IND_BIT] ? mbr[AW-1:0] : ir[AW-1:0];
    end

    // Register transfers performed in each subcycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc     <= RESET_PC;
            sp     <= SP_INIT;
            mar    <= '0;
            mbr    <= '0;
            ir     <= '0;
            acc    <= '0;
            irq_en <= 1'b1;
        end else begin
            case (st)
                S_FETCH_A: mar <= pc;
                S_FETCH_M: if (mem_ready) begin
                    mbr <= mem_rdata;
                    pc  <= pc + AW'(1);
                end
                S_LOAD_IR: ir <= mbr;
                S_IND_A:   mar <= ir[AW-1:0];
                S_IND_M:   if (mem_ready) mbr <= mem_rdata;
                S_EXEC_A: begin
                    mar <= ea;
                    if (op == OP_STORE) mbr <= acc;
                    if (op == OP_JUMP)  pc  <= ea;
                end
                S_EXEC_RD: if (mem_ready) mbr <= mem_rdata;
                S_EXEC_OP: acc <= (op == OP_LOAD) ? mbr : acc + mbr;
                S_INT_A: begin
                    mbr    <= DW'(pc);
                    mar    <= sp;
                    irq_en <= 1'b0;
                end
                S_INT_WR: if (mem_ready) begin
                    sp <= sp - AW'(1);
                    pc <= IRQ_VEC;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/icc_core.sv
// Top of the instruction cycle controller. Joins the sequencer and the
// register file and derives the memory strobes from the subcycle.
// Assumes one outstanding memory access at a time.
module icc_core
    import icc_pkg::*;
#(
    parameter int          DW       = 16,
    parameter int          AW       = 11,
    parameter logic [AW-1:0] RESET_PC = '0,
    parameter logic [AW-1:0] SP_INIT  = '1,
    parameter logic [AW-1:0] IRQ_VEC  = AW'(256)
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [AW-1:0] mem_addr,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    input  logic          mem_ready,
    input  logic          irq,
    output logic          irq_en
);

    state_e        st;
    logic [AW-1:0] mar;
    logic [DW-1:0] mbr;
    logic [DW-1:0] ir;

    icc_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .mem_ready (mem_ready),
        .irq       (irq),
        .irq_en    (irq_en),
        .mbr_ind   (mbr[DW-5]),
        .ir_op     (ir[DW-1:DW-4]),
        .st        (st)
    );

    icc_regs #(
        .DW       (DW),
        .AW       (AW),
        .RESET_PC (RESET_PC),
        .SP_INIT  (SP_INIT),
        .IRQ_VEC  (IRQ_VEC)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .st        (st),
        .mem_ready (mem_ready),
        .mem_rdata (mem_rdata),
        .mar       (mar),
        .mbr       (mbr),
        .ir        (ir),
        .irq_en    (irq_en)
    );

    // Memory port: address and data come from the holding registers.
    always_comb begin
        mem_addr  = mar;
        mem_wdata = mbr;
        mem_rd    = (st == S_FETCH_M) || (st == S_IND_M) || (st == S_EXEC_RD);
        mem_wr    = (st == S_EXEC_WR) || (st == S_INT_WR);
    end

endmodule

// File: rtl/icc_chk.sv
// Protocol and interrupt checks for icc_core, attached by bind.
module icc_chk #(
    parameter int DW = 16,
    parameter int AW = 11
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] mem_addr,
    input logic          mem_rd,
    input logic          mem_wr,
    input logic [DW-1:0] mem_wdata,
    input logic          mem_ready,
    input logic          irq_en
);

    // R7
    hold_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((mem_rd || mem_wr) && !mem_ready) |=>
            ($stable(mem_rd) && $stable(mem_wr) && $stable(mem_addr) && $stable(mem_wdata)));

    // R7
    one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    // R8
    push_on_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_en) |-> mem_wr);

    // R9
    enable_stays_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |=> !irq_en);

endmodule

bind icc_core icc_chk #(.DW(DW), .AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_addr  (mem_addr),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .mem_wdata (mem_wdata),
    .mem_ready (mem_ready),
    .irq_en    (irq_en)
);

// File: tb/sim_icc_core.sv
// Scoreboard bench: expected bus transactions are queued by the driver,
// the memory model pops and compares each one as it completes.
module sim_icc_core;

    typedef struct packed {
        logic        wr;
        logic [10:0] a;
        logic [15:0] d;
    } txn_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [10:0] mem_addr;
    logic        mem_rd;
    logic        mem_wr;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata = '0;
    logic        mem_ready = 1'b0;
    logic        irq = 1'b0;
    logic        irq_en;

    logic [15:0] mem [0:2047];
    txn_t        exp_q[$];
    string       tag_q[$];
    int          n_chk = 0;
    int          n_err = 0;
    int          n_txn = 0;
    int          wait_cyc = 0;
    int          cnt = 0;
    int          cycles = 0;

    icc_core u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .mem_addr  (mem_addr),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .mem_ready (mem_ready),
        .irq       (irq),
        .irq_en    (irq_en)
    );

    // 125 MHz clock.
    always #4 clk = ~clk;

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_err++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    task automatic expect_rd(input logic [10:0] a, input string tag);
        exp_q.push_back('{wr: 1'b0, a: a, d: 16'h0});
        tag_q.push_back(tag);
    endtask

    task automatic expect_wr(input logic [10:0] a, input logic [15:0] d, input string tag);
        exp_q.push_back('{wr: 1'b1, a: a, d: d});
        tag_q.push_back(tag);
    endtask

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Memory model and monitor: ready after wait_cyc cycles, one-cycle pulse.
    always @(negedge clk) begin
        if (!rst_n) begin
            mem_ready = 1'b0;
            cnt = 0;
        end else if (mem_ready) begin
            mem_ready = 1'b0;
            cnt = 0;
        end else if (mem_rd || mem_wr) begin
            if (cnt >= wait_cyc) begin
                txn_t e;
                string t;
                if (mem_wr) mem[mem_addr] = mem_wdata;
                else        mem_rdata = mem[mem_addr];
                mem_ready = 1'b1;
                n_txn++;
                if (exp_q.size() > 0) begin
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(mem_wr == e.wr && mem_addr == e.a && (!e.wr || mem_wdata == e.d), t,
                          "bus {wr,addr,data}",
                          {mem_wr, mem_addr, mem_wr ? mem_wdata : 16'h0},
                          {e.wr, e.a, e.d});
                end
            end else begin
                cnt++;
            end
        end
    end

    task automatic load_program();
        for (int i = 0; i < 2048; i++) mem[i] = 16'h0000;
        mem[0]  = 16'h1014;  // load 20
        mem[1]  = 16'h3815;  // add indirect via 21
        mem[2]  = 16'h201E;  // store 30
        mem[3]  = 16'h2817;  // store indirect via 23
        mem[4]  = 16'h0000;  // no-op
        mem[5]  = 16'h7014;  // unassigned opcode
        mem[6]  = 16'h4008;  // jump 8
        mem[8]  = 16'h4818;  // jump indirect via 24
        mem[10] = 16'h2020;  // store 32
        mem[11] = 16'h400B;  // jump to self
        mem[20] = 16'hFFFE;
        mem[21] = 16'hF816;  // pointer, upper bits set, low 11 bits = 22
        mem[22] = 16'h0005;
        mem[23] = 16'h001F;  // pointer to 31
        mem[24] = 16'h000A;  // pointer to 10
        mem[256] = 16'h1014; // handler: load 20
        mem[257] = 16'h2021; // store 33
        mem[258] = 16'h4102; // jump to self
    endtask

    task automatic run(input int ws);
        wait_cyc = ws;
        irq = 1'b0;
        n_txn = 0;
        rst_n = 1'b0;
        load_program();
        repeat (3) @(negedge clk);
        // R1: quiet bus and enable set while held in reset
        check(!mem_rd && !mem_wr, "R1", "strobes in reset", {mem_rd, mem_wr}, 0);
        check(irq_en == 1'b1, "R1", "irq_en in reset", irq_en, 1);
        expect_rd(11'd0,   "R1");
        expect_rd(11'd20,  "R3");
        expect_rd(11'd1,   "R2");
        expect_rd(11'd21,  "R4");
        expect_rd(11'd22,  "R4");
        expect_rd(11'd2,   "R2");
        expect_wr(11'd30,  16'h0003, "R3");
        expect_rd(11'd3,   "R2");
        expect_rd(11'd23,  "R4");
        expect_wr(11'd31,  16'h0003, "R5");
        expect_rd(11'd4,   "R6");
        expect_rd(11'd5,   "R6");
        expect_rd(11'd6,   "R6");
        expect_rd(11'd8,   "R6");
        expect_rd(11'd24,  "R4");
        expect_rd(11'd10,  "R6");
        expect_wr(11'd32,  16'h0003, "R5");
        expect_rd(11'd11,  "R2");
        expect_wr(11'h7FF, 16'h000B, "R8");
        expect_rd(11'h100, "R8");
        expect_rd(11'd20,  "R3");
        expect_rd(11'h101, "R2");
        expect_wr(11'd33,  16'hFFFE, "R5");
        expect_rd(11'h102, "R9");
        expect_rd(11'h102, "R9");
        expect_rd(11'h102, "R9");
        rst_n = 1'b1;
        // raise the request once the jump-to-self has been fetched
        wait (n_txn == 18);
        irq = 1'b1;
        wait (exp_q.size() == 0);
        @(negedge clk);
        // R8: enable flag cleared after entry, R9: request still high and ignored
        check(irq_en == 1'b0, "R8", "irq_en after entry", irq_en, 0);
        check(mem[11'h7FE] == 16'h0000, "R9", "no second push", mem[11'h7FE], 0);
    endtask

    // Driver: two passes with different wait states.
    initial begin
        run(0);
        run(3);
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule